// File: doc/BRIEF.md
# External Clock Bypass Controller

This block decides when the chip's IO and system clocks move from the internal oscillators to an external source. It runs the request and acknowledge handshakes with the analog clock block. A bypass can be asked for in two ways. Software can ask through a control field, and that request counts only while the life-cycle debug-enable input carries its On code. The life-cycle controller can also ask directly with its own request input.

While an external clock is selected, the block can also order the IO clock dividers to divide by a further factor of two. Scan mode forbids this step-down. Once the IO bypass acknowledge and every divider's step-down acknowledge have arrived, the block returns an acknowledge to the life-cycle controller.

Every control value is a 4-bit multibit code, and every acknowledge input is resynchronised before it is used. Every output is registered. The divider circuits, the analog switching and the register file that holds the software fields are not part of this block.

Top module: `extclk_bypass_ctrl`

## Requirements
- R1: `all_req_o` becomes multibit true (4'h6) one cycle after `sw_sel_i` is multibit true and `dbg_en_i` is the life-cycle On code (4'hA). In every other cycle it is multibit false (4'h9).
- R2: A `dbg_en_i` value that is neither On (4'hA) nor Off (4'h5) leaves `all_req_o` at multibit false.
- R3: `io_req_o` becomes multibit true one cycle after `lc_req_i` equals On (4'hA). Every other `lc_req_i` code, valid or not, gives multibit false.
- R4: `step_down_o` is multibit true one cycle after an external clock is requested with the speed condition met. That is either `lc_req_i` equal to On, or the R1 software condition together with `sw_hispeed_i` equal to multibit true. Otherwise `step_down_o` is multibit false.
- R5: While `scan_i` is multibit true, `step_down_o` is multibit false.
- R6: `status_o` carries the value of `all_ack_i` unchanged, two clock edges after it is applied (two-stage synchroniser).
- R7: `lc_ack_o` equals the value `lc_req_i` had one cycle earlier, but only when the synchronised `io_ack_i` and every synchronised 4-bit field of `step_ack_i` are multibit true. Field k is bits [4k+3:4k]. Otherwise `lc_ack_o` is Off (4'h5). The acknowledge inputs take two edges to synchronise and one more to reach `lc_ack_o`.
- R8: An acknowledge code that is neither multibit true nor false counts as not true and can never produce an acknowledge.
- R9: `jitter_o` equals `sw_jitter_i` one cycle later.
- R10: While `rst` is high at a clock edge, the requests, the step-down and `jitter_o` go to multibit false, `lc_ack_o` goes to Off, and `status_o` goes to multibit false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sel_i | input | 4 | Software external-clock select field (multibit) |
| sw_hispeed_i | input | 4 | Software high-speed select field (multibit) |
| sw_jitter_i | input | 4 | Software jitter field (multibit) |
| dbg_en_i | input | 4 | Life-cycle debug enable (life-cycle code) |
| lc_req_i | input | 4 | Life-cycle bypass request (life-cycle code) |
| scan_i | input | 4 | Scan mode (multibit) |
| all_ack_i | input | 4 | All-clock bypass acknowledge (multibit, asynchronous) |
| io_ack_i | input | 4 | IO clock bypass acknowledge (multibit, asynchronous) |
| step_ack_i | input | 4*NDIV | Divider step-down acknowledges, one 4-bit field per divider |
| all_req_o | output | 4 | All-clock bypass request |
| io_req_o | output | 4 | IO clock bypass request |
| step_down_o | output | 4 | Divider step-down command |
| lc_ack_o | output | 4 | Acknowledge to the life-cycle controller |
| status_o | output | 4 | Status copy of the all-clock acknowledge |
| jitter_o | output | 4 | Jitter enable |

## Verification
If a decision register held a wrong value, it would show up on a request output or `step_down_o` in the very next cycle. A corrupted synchroniser stage would appear on `status_o` within two edges and on `lc_ack_o` within three. The bench models the synchroniser delay independently and compares all six outputs on every cycle. Because of that, a wrong code, a missing qualifier or an off-by-one delay in the acknowledge path would be caught within a few cycles of the stimulus that exposes it. The stimulus mixes valid codes with arbitrary invalid codes on every multibit input.

// File: rtl/extclk_bypass_pkg.sv
package extclk_bypass_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MB_TRUE  = 4'h6;
  localparam code_t MB_FALSE = 4'h9;
  localparam code_t LC_ON    = 4'hA;
  localparam code_t LC_OFF   = 4'h5;
endpackage

// File: rtl/bypass_sync.sv
module bypass_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bypass_decide.sv
module bypass_decide
  import extclk_bypass_pkg::*;
(
  input  code_t sel,
  input  code_t hispeed,
  input  code_t dbg_en,
  input  code_t lc_req,
  input  code_t scan,
  output logic  sw_ext,
  output logic  lc_ext,
  output logic  step
);
  logic speed_ok;

  always_comb begin
    sw_ext   = (sel == MB_TRUE) && (dbg_en == LC_ON);
    lc_ext   = (lc_req == LC_ON);
    speed_ok = lc_ext || (sw_ext && (hispeed == MB_TRUE));
    step     = speed_ok && (scan != MB_TRUE);
  end
endmodule

// File: rtl/extclk_bypass_ctrl.sv
module extclk_bypass_ctrl
  import extclk_bypass_pkg::*;
#(
  parameter int NDIV = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            sw_sel_i,
  input  logic [3:0]            sw_hispeed_i,
  input  logic [3:0]            sw_jitter_i,
  input  logic [3:0]            dbg_en_i,
  input  logic [3:0]            lc_req_i,
  input  logic [3:0]            scan_i,
  input  logic [3:0]            all_ack_i,
  input  logic [3:0]            io_ack_i,
  input  logic [4*NDIV-1:0]     step_ack_i,
  output logic [3:0]            all_req_o,
  output logic [3:0]            io_req_o,
  output logic [3:0]            step_down_o,
  output logic [3:0]            lc_ack_o,
  output logic [3:0]            status_o,
  output logic [3:0]            jitter_o
);
  localparam int ACK_W = CODE_W * NDIV;

  logic sw_ext, lc_ext, step;
  code_t all_ack_s, io_ack_s;
  logic [ACK_W-1:0] div_ack_s;
  logic [NDIV-1:0]  div_true;
  logic             handshake_done;

  bypass_decide u_decide (
    .sel(sw_sel_i), .hispeed(sw_hispeed_i), .dbg_en(dbg_en_i),
    .lc_req(lc_req_i), .scan(scan_i),
    .sw_ext(sw_ext), .lc_ext(lc_ext), .step(step)
  );

  bypass_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL(MB_FALSE)) u_sync_all (
    .clk(clk), .rst(rst), .d(all_ack_i), .q(all_ack_s)
  );

  bypass_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL(MB_FALSE)) u_sync_io (
    .clk(clk), .rst(rst), .d(io_ack_i), .q(io_ack_s)
  );

  bypass_sync #(.W(ACK_W), .STAGES(SYNC_STAGES), .RST_VAL({NDIV{MB_FALSE}})) u_sync_div (
    .clk(clk), .rst(rst), .d(step_ack_i), .q(div_ack_s)
  );

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    assign div_true[k] = (div_ack_s[k*CODE_W +: CODE_W] == MB_TRUE);
  end

  assign handshake_done = (io_ack_s == MB_TRUE) && (&div_true);

  always_ff @(posedge clk) begin
    if (rst) begin
      all_req_o   <= MB_FALSE;
      io_req_o    <= MB_FALSE;
      step_down_o <= MB_FALSE;
      jitter_o    <= MB_FALSE;
      lc_ack_o    <= LC_OFF;
    end else begin
      all_req_o   <= sw_ext ? MB_TRUE : MB_FALSE;
      io_req_o    <= lc_ext ? MB_TRUE : MB_FALSE;
      step_down_o <= step ? MB_TRUE : MB_FALSE;
      jitter_o    <= sw_jitter_i;
      lc_ack_o    <= handshake_done ? lc_req_i : LC_OFF;
    end
  end

  assign status_o = all_ack_s;

  AST_ALL_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (all_req_o == MB_TRUE) |-> $past(sw_sel_i == MB_TRUE && dbg_en_i == LC_ON)); // R2
  AST_IO_REQ_FROM_LC: assert property (@(posedge clk) disable iff (rst)
    (io_req_o == MB_TRUE) |-> $past(lc_req_i == LC_ON)); // R3
  AST_NO_STEP_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    (step_down_o == MB_TRUE) |-> $past(scan_i != MB_TRUE)); // R5
  AST_LC_ACK_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    (lc_ack_o != LC_OFF) |-> $past(io_ack_s == MB_TRUE && div_ack_s == {NDIV{MB_TRUE}})); // R7
endmodule

// File: tb/extclk_bypass_ctrl_test.sv
`timescale 1ns/1ps
module extclk_bypass_ctrl_test;
  localparam int NDIV = 2;
  localparam logic [3:0] T = 4'h6, F = 4'h9, ON = 4'hA, OFF = 4'h5;

  logic clk = 0, rst = 1;
  logic [3:0] sel = F, hs = F, jit = F, dbg = OFF, lcr = OFF, scan = F, aack = F, iack = F;
  logic [4*NDIV-1:0] sack = {NDIV{F}};
  logic [3:0] all_req, io_req, step, lc_ack, status, jitter;

  int checks = 0, errors = 0;
  bit active = 0, finished = 0;

  extclk_bypass_ctrl #(.NDIV(NDIV)) uut (
    .clk(clk), .rst(rst), .sw_sel_i(sel), .sw_hispeed_i(hs), .sw_jitter_i(jit),
    .dbg_en_i(dbg), .lc_req_i(lcr), .scan_i(scan), .all_ack_i(aack), .io_ack_i(iack),
    .step_ack_i(sack), .all_req_o(all_req), .io_req_o(io_req), .step_down_o(step),
    .lc_ack_o(lc_ack), .status_o(status), .jitter_o(jitter)
  );

  always #10 clk = ~clk;

  // behavioural reference: queues model the acknowledge synchroniser delay
  logic [3:0] m_all, m_io, m_step, m_lc, m_stat, m_jit;
  logic [3:0] qa[$], qi[$];
  logic [4*NDIV-1:0] qd[$];
  string tag_all, tag_step, tag_lc;

  function automatic bit bad(logic [3:0] c);
    return (c != T) && (c != F);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_all = F; m_io = F; m_step = F; m_jit = F; m_lc = OFF; m_stat = F;
      qa = '{F, F}; qi = '{F, F}; qd = '{{NDIV{F}}, {NDIV{F}}};
    end else begin
      bit done, inv, swx;
      done = (qi[1] == T);
      inv = bad(qi[1]);
      for (int k = 0; k < NDIV; k++) begin
        if (qd[1][4*k +: 4] != T) done = 0;
        if (bad(qd[1][4*k +: 4])) inv = 1;
      end
      m_lc = done ? lcr : OFF;
      tag_lc = inv ? "R8" : "R7";
      qa.pop_back(); qa.push_front(aack);
      qi.pop_back(); qi.push_front(iack);
      qd.pop_back(); qd.push_front(sack);
      m_stat = qa[1];
      swx = (sel == T) && (dbg == ON);
      m_all = swx ? T : F;
      tag_all = (dbg != ON && dbg != OFF) ? "R2" : "R1";
      m_io = (lcr == ON) ? T : F;
      m_step = ((scan != T) && ((lcr == ON) || (swx && hs == T))) ? T : F;
      tag_step = (scan == T) ? "R5" : "R4";
      m_jit = jit;
    end
  end

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (active && !finished) begin
    chk(tag_all, "all_req", all_req, m_all);
    chk("R3", "io_req", io_req, m_io);
    chk(tag_step, "step_down", step, m_step);
    chk(tag_lc, "lc_ack", lc_ack, m_lc);
    chk("R6", "status", status, m_stat);
    chk("R9", "jitter", jitter, m_jit);
  end

  function automatic logic [3:0] pick(logic [3:0] good, logic [3:0] other);
    int r = $urandom_range(0, 99);
    if (r < 55) return good;
    if (r < 80) return other;
    return 4'($urandom_range(0, 15));
  endfunction

  initial begin
    // drive non-default values during reset to show reset dominates (R10)
    sel = T; dbg = ON; lcr = ON; jit = T; aack = T; iack = T; sack = {NDIV{T}};
    repeat (3) @(negedge clk);
    chk("R10", "all_req reset", all_req, F);
    chk("R10", "io_req reset", io_req, F);
    chk("R10", "step reset", step, F);
    chk("R10", "lc_ack reset", lc_ack, OFF);
    chk("R10", "status reset", status, F);
    chk("R10", "jitter reset", jitter, F);
    rst = 0; active = 1;
    // directed: full life-cycle handshake
    repeat (5) @(negedge clk);
    // directed: software path with scan blocking step-down (R5), bad debug code (R2)
    lcr = OFF; hs = T; scan = T; @(negedge clk);
    scan = F; @(negedge clk);
    dbg = 4'h3; @(negedge clk);
    dbg = ON; iack = 4'h0; repeat (4) @(negedge clk);  // R8 invalid ack
    for (int n = 0; n < 4000; n++) begin
      sel  = pick(T, F);
      hs   = pick(T, F);
      jit  = pick(T, F);
      dbg  = pick(ON, OFF);
      lcr  = pick(ON, OFF);
      scan = pick(F, T);
      aack = pick(T, F);
      iack = pick(T, F);
      for (int k = 0; k < NDIV; k++) sack[4*k +: 4] = pick(T, F);
      @(negedge clk);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule